// File: doc/BRIEF.md
# Time-Switched Bimodal-to-Gshare Direction Predictor

This block predicts the direction of conditional branches. In its first phase it answers from a small table of 2-bit saturating counters indexed only by low bits of the branch address. That table is cheap and learns quickly, so it copes well with a cold start. A larger table of 2-bit counters runs alongside it. This second table is indexed by the branch address XORed with a global register holding recent branch outcomes. Both tables and the history register train on every resolved branch from reset onward. As a result the history-indexed table is already warm when it takes over.

A single counter counts resolved branches. Once it reaches a threshold set at build time, every later prediction comes from the history-indexed table, and the choice never reverts until reset. There is no per-branch chooser. The lookup is combinational: an address presented in a cycle gets its answer in that same cycle, based on the state left by the previous clock edge. Resolution arrives on a separate update port with a valid strobe.

Top module: `bimodal_gshare_predictor`

## Requirements
- R1: After reset every counter in both tables holds 2'b01, the outcome history is all zeros, and every lookup answers not-taken.
- R2: `predTaken` is the most significant bit of the counter chosen by the active table for `predPc`, in the same cycle that `predPc` is presented.
- R3: The small table has 64 entries indexed by `pc[7:2]`. Addresses that differ only outside bits 7:2 share an entry.
- R4: The large table has 1024 entries indexed by `pc[11:2] XOR hist[9:0]`, where `hist` is the current 10-bit outcome history.
- R5: On each valid update, the addressed counter in each table increments when the branch was taken and decrements when it was not. Counters stop at 2'b11 and 2'b00.
- R6: On each valid update, the history shifts left by one and the actual outcome enters bit 0 (1 = taken). The large table's update index uses the history as it stood before that shift.
- R7: Both tables train on every valid update, before and after the hand-over.
- R8: Until `SWITCH_AFTER` valid updates have been seen, lookups use the small table. From the edge that completes update number `SWITCH_AFTER` onward, they use the large table.
- R9: The hand-over is permanent. Any number of further updates leaves the large table selected until reset.
- R10: While `updValid` is low, no counter and no history bit changes, whatever `updPc` and `updTaken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| predPc | input | PC_W | Address of the branch being looked up |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| updValid | input | 1 | A branch has resolved this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The bench builds the predictor with a hand-over threshold of 24 and keeps an arithmetic model of both tables, the history and the update count.

Counter saturation is checked at both ends. A counter that wraps from 11 to 00 would predict not-taken after a long run of taken outcomes.

Aliasing is checked on addresses that differ above bit 7. If the small table used the wrong address bits, those addresses would stop sharing an entry.

The cycles around the hand-over are checked closely. A design that switched one update early or late, or that did not train the large table beforehand, would give wrong answers just after the switch.

A long run past the threshold targets a switch counter that wraps. Such a counter would drop back to the small table.

Idle cycles with junk on the update port target a design that trains without the valid strobe, which would corrupt the answers that follow.

// File: rtl/bgp_pkg.sv
package bgp_pkg;

  // Strobes from the control side to the tables.
  typedef struct packed {
    logic trainEn;    // a resolved branch is being written this cycle
    logic useGshare;  // lookup answers from the history-indexed table
  } predCtrlT;

  localparam logic [1:0] CTR_RESET = 2'b01;

  // Saturating 2-bit counter step.
  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/bgp_counter_table.sv
module bgp_counter_table
  import bgp_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdTaken,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrTaken
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [1:0] ctrMem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ctrMem[i] <= CTR_RESET;
    end else if (wrEn) begin
      ctrMem[wrIdx] <= satStep(ctrMem[wrIdx], wrTaken);
    end
  end

  assign rdTaken = ctrMem[rdIdx][1];

endmodule

// File: rtl/bgp_switch_ctrl.sv
module bgp_switch_ctrl
  import bgp_pkg::*;
#(
  parameter int unsigned HIST_W       = 10,
  parameter int unsigned SWITCH_AFTER = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  input  logic              updTaken,
  output predCtrlT          ctrl,
  output logic [HIST_W-1:0] histQ
);

  localparam int unsigned CNT_W = $clog2(SWITCH_AFTER + 2);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SWITCH_AFTER);

  logic [CNT_W-1:0] switchCnt;
  logic             switched;

  assign switched = (switchCnt >= CNT_LIMIT);

  // Counts resolved branches and stops once the limit is reached, so it cannot wrap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     switchCnt <= '0;
    else if (updValid && !switched) switchCnt <= switchCnt + 1'b1;
  end

  // Global outcome history, shifted on resolution.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         histQ <= '0;
    else if (updValid) histQ <= {histQ[HIST_W-2:0], updTaken};
  end

  always_comb begin
    ctrl.trainEn   = updValid;
    ctrl.useGshare = switched;
  end

endmodule

// File: rtl/bgp_tables.sv
module bgp_tables
  import bgp_pkg::*;
#(
  parameter int unsigned LOCAL_IDX_W = 6,
  parameter int unsigned GSH_IDX_W   = 10,
  parameter int unsigned HIST_W      = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  predCtrlT             ctrl,
  input  logic [HIST_W-1:0]    histQ,
  input  logic [GSH_IDX_W-1:0] predBits,
  input  logic [GSH_IDX_W-1:0] updBits,
  input  logic                 updTaken,
  output logic                 predTaken
);

  logic [GSH_IDX_W-1:0] histFold;
  logic                 localRd;
  logic                 gshRd;

  // Fit the history onto the large-table index width.
  generate
    if (HIST_W >= GSH_IDX_W) begin : g_histTrunc
      assign histFold = histQ[GSH_IDX_W-1:0];
    end else begin : g_histExt
      assign histFold = {{(GSH_IDX_W - HIST_W){1'b0}}, histQ};
    end
  endgenerate

  bgp_counter_table #(.IDX_W(LOCAL_IDX_W)) u_localTab (
    .clk     (clk),
    .rstN    (rstN),
    .rdIdx   (predBits[LOCAL_IDX_W-1:0]),
    .rdTaken (localRd),
    .wrEn    (ctrl.trainEn),
    .wrIdx   (updBits[LOCAL_IDX_W-1:0]),
    .wrTaken (updTaken)
  );

  bgp_counter_table #(.IDX_W(GSH_IDX_W)) u_gshTab (
    .clk     (clk),
    .rstN    (rstN),
    .rdIdx   (predBits ^ histFold),
    .rdTaken (gshRd),
    .wrEn    (ctrl.trainEn),
    .wrIdx   (updBits ^ histFold),
    .wrTaken (updTaken)
  );

  assign predTaken = ctrl.useGshare ? gshRd : localRd;

endmodule

// File: rtl/bimodal_gshare_predictor.sv
module bimodal_gshare_predictor
  import bgp_pkg::*;
#(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned PC_SHIFT     = 2,
  parameter int unsigned LOCAL_IDX_W  = 6,
  parameter int unsigned GSH_IDX_W    = 10,
  parameter int unsigned HIST_W       = 10,
  parameter int unsigned SWITCH_AFTER = 4096
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] predPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  localparam int unsigned IDX_LO = PC_SHIFT;
  localparam int unsigned IDX_HI = PC_SHIFT + GSH_IDX_W;

  predCtrlT          ctrlS;
  logic [HIST_W-1:0] histS;
  logic              unusedPcBits;

  // Address bits outside the index field carry no information here.
  assign unusedPcBits = ^{predPc[PC_W-1:IDX_HI], predPc[IDX_LO-1:0],
                          updPc[PC_W-1:IDX_HI], updPc[IDX_LO-1:0]};

  bgp_switch_ctrl #(
    .HIST_W       (HIST_W),
    .SWITCH_AFTER (SWITCH_AFTER)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updTaken (updTaken),
    .ctrl     (ctrlS),
    .histQ    (histS)
  );

  bgp_tables #(
    .LOCAL_IDX_W (LOCAL_IDX_W),
    .GSH_IDX_W   (GSH_IDX_W),
    .HIST_W      (HIST_W)
  ) u_tables (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlS),
    .histQ     (histS),
    .predBits  (predPc[IDX_LO +: GSH_IDX_W]),
    .updBits   (updPc[IDX_LO +: GSH_IDX_W]),
    .updTaken  (updTaken),
    .predTaken (predTaken)
  );

endmodule

// File: rtl/bgp_checker.sv
module bgp_checker #(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned HIST_W       = 10,
  parameter int unsigned SWITCH_AFTER = 4096
) (
  input logic              clk,
  input logic              rstN,
  input logic              updValid,
  input logic              updTaken,
  input logic [PC_W-1:0]   predPc,
  input logic              predTaken,
  input logic              useGshare,
  input logic [HIST_W-1:0] histQ
);

  // Independent count of resolved branches, held at the limit.
  int unsigned seenCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   seenCnt <= 0;
    else if (updValid && seenCnt < SWITCH_AFTER) seenCnt <= seenCnt + 1;
  end

  assert_sel_by_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    useGshare == (seenCnt >= SWITCH_AFTER));

  assert_switch_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    useGshare |=> useGshare);

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> (histQ[0] == $past(updTaken)) &&
                 (histQ[HIST_W-1:1] == $past(histQ[HIST_W-2:0])));

  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ));

  assert_pred_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!updValid && !useGshare) |=> (!$stable(predPc) || $stable(predTaken)));

  assert_reset_local_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (histQ == '0));

endmodule

bind bimodal_gshare_predictor bgp_checker #(
  .PC_W         (PC_W),
  .HIST_W       (HIST_W),
  .SWITCH_AFTER (SWITCH_AFTER)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .updValid  (updValid),
  .updTaken  (updTaken),
  .predPc    (predPc),
  .predTaken (predTaken),
  .useGshare (ctrlS.useGshare),
  .histQ     (histS)
);

// File: tb/bimodal_gshare_predictor_tb.sv
module bimodal_gshare_predictor_tb;

  localparam int THRESH = 24;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] predPc;
  logic        predTaken;
  logic        updValid;
  logic [31:0] updPc;
  logic        updTaken;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  // Arithmetic model
  int          mLoc [64];
  int          mGsh [1024];
  logic [9:0]  mHist;
  int          mCnt;
  logic [31:0] rs = 32'h1234_5679;

  always #4 clk = ~clk;  // 125 MHz

  bimodal_gshare_predictor #(.SWITCH_AFTER(THRESH)) u_dut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic int locIdx(input logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic int gIdx(input logic [31:0] pc);
    return int'(pc[11:2] ^ mHist);
  endfunction

  function automatic bit expPred(input logic [31:0] pc);
    if (mCnt >= THRESH) return mGsh[gIdx(pc)] >= 2;
    return mLoc[locIdx(pc)] >= 2;
  endfunction

  function automatic int sat(input int c, input bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic logic [31:0] nextRand();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic check(input logic [31:0] pc, input string tag);
    bit e;
    @(negedge clk);
    predPc = pc;
    #1;
    e = expPred(pc);
    nChecks++;
    if (predTaken !== e) begin
      nFails++;
      $display("FAIL %s pc=%h actual=%0b expected=%0b", tag, pc, predTaken, e);
    end
  endtask

  task automatic update(input logic [31:0] pc, input bit t);
    int li;
    int gi;
    @(negedge clk);
    updValid = 1'b1;
    updPc    = pc;
    updTaken = t;
    @(posedge clk);
    li = locIdx(pc);
    gi = gIdx(pc);           // history before the shift
    mLoc[li] = sat(mLoc[li], t);
    mGsh[gi] = sat(mGsh[gi], t);
    mHist = {mHist[8:0], t};
    if (mCnt < THRESH) mCnt++;
    #1;
    updValid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    int postCnt;
    string tag;

    pool[0] = 32'h0000_1000; pool[1] = 32'h0000_1044; pool[2] = 32'h0000_2108;
    pool[3] = 32'h0000_30FC; pool[4] = 32'h0001_1000; pool[5] = 32'h0000_0A30;
    pool[6] = 32'h0000_5554; pool[7] = 32'h0000_07C0;

    for (int i = 0; i < 64; i++)   mLoc[i] = 1;
    for (int i = 0; i < 1024; i++) mGsh[i] = 1;
    mHist = '0;
    mCnt  = 0;

    rstN = 1'b0; predPc = '0; updValid = 1'b0; updPc = '0; updTaken = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: every small-table entry starts weakly not-taken
    for (int i = 0; i < 64; i++) check(32'(i) << 2, "R1");
    check(32'hFFFF_FFFC, "R1");

    // R5: climb to the top and saturate there
    update(32'h40, 1); check(32'h40, "R5");
    update(32'h40, 1); check(32'h40, "R5");
    update(32'h40, 1); check(32'h40, "R5");
    update(32'h40, 0); check(32'h40, "R5");
    // R3: an alias above bit 7 shares the entry, a neighbour does not
    check(32'h140, "R3");
    check(32'hABC0_0040, "R3");
    check(32'h44, "R3");
    // R5: fall to the bottom and saturate there
    update(32'h40, 0); check(32'h40, "R5");
    update(32'h40, 0); check(32'h40, "R5");
    update(32'h40, 0); check(32'h40, "R5");
    update(32'h40, 1); check(32'h40, "R5");
    update(32'h40, 1); check(32'h40, "R5");

    // R10: junk on the update port with valid low changes nothing
    update(32'h80, 1);
    update(32'h80, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      updValid = 1'b0;
      updPc    = 32'h80;
      updTaken = (i % 2) == 0;
    end
    check(32'h80, "R10");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      updValid = 1'b0;
      updPc    = 32'hC4;
      updTaken = 1'b1;
    end
    check(32'hC4, "R10");
    check(32'h40, "R10");

    // Mixed stream across the hand-over and far beyond it
    postCnt = 0;
    for (int step = 0; step < 420; step++) begin
      logic [31:0] pc;
      logic [31:0] r;
      bit t;
      r  = nextRand();
      pc = pool[r[2:0]];
      t  = (pc[4] ^ mHist[0] ^ mHist[2]) | (r[15:12] == 4'hF);
      update(pc, t);
      if (mCnt >= THRESH) postCnt++;
      if (mCnt < THRESH - 1)        tag = "R2";
      else if (postCnt <= 2)        tag = "R8";
      else if (postCnt <= 40)       tag = "R7";
      else if (postCnt <= 120)      tag = "R4";
      else if (postCnt <= 200)      tag = "R6";
      else                          tag = "R9";
      check(pool[nextRand() % 8], tag);
      check(pc, tag);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule